// File: doc/BRIEF.md
# Vector Domain Reset Sequencer

This block brings a separately powered vector/SIMD logic domain out of powerdown in a controlled order. On a start request it asserts the domain's active-low reset with the domain clock still running. It then raises an active-high clock-stop request while reset is still held, releases reset under the stopped clock, and finally lets the clock run again. Because the clock restarts only after reset has been released, every register in the domain sees the same first edge.

Each of the three waits has a programmable length, taken from configuration inputs or from parameters. Each length is clamped to a safe minimum. A busy flag covers the sequence and a one-cycle done pulse marks its end, so a power controller knows when the domain is usable. A hold input keeps the domain in reset for as long as it is high, which is the safe condition for switching domain power. When hold is released the whole sequence starts again from its first step. This domain reset has no link to the main core reset or the debug reset.

Top module: `vec_rst_seq`

## Requirements
- R1: While the block's own asynchronous reset `rst_n` is low, and immediately when it goes low, `dom_rst_n_o`=0, `dom_clk_stop_o`=0, `busy_o`=0 and `done_o`=0.
- R2: A start pulse sampled in the idle or done state makes `busy_o`=1 from the next cycle. `dom_rst_n_o`=0 and `dom_clk_stop_o`=0 are then held for exactly L1 cycles, where L1 is the assert-phase length.
- R3: After that phase, `dom_clk_stop_o`=1 with `dom_rst_n_o` still 0 for exactly L2 cycles.
- R4: Next, `dom_rst_n_o`=1 while `dom_clk_stop_o` stays 1 for exactly L3 cycles. Reset is only ever released while clock-stop is high.
- R5: After the release phase, `dom_clk_stop_o`=0, `dom_rst_n_o`=1 and `busy_o`=0. `done_o` is 1 for exactly the first such cycle and 0 afterwards.
- R6: A start pulse that arrives while `busy_o`=1 is ignored. The sequence in progress keeps its phase and its remaining count.
- R7: While `hold_i`=1, from the cycle after it is sampled, `dom_rst_n_o`=0, `dom_clk_stop_o`=0 and `busy_o`=0, whatever phase was active.
- R8: In the cycle after `hold_i` is first sampled low following a high, the full sequence starts from the assert phase (`busy_o`=1) with no start pulse.
- R9: The phase lengths L1, L2 and L3 come from the three configuration inputs, or from parameters when `USE_CFG_PORTS`=0. They are clamped up to minimums of 9, 1 and 1 cycles, so a value of 3 gives L1=9 and a value of 0 gives L2=L3=1.
- R10: A start pulse in the done state restarts the sequence: in the next cycle `dom_rst_n_o`=0 and `busy_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| start_i | input | 1 | Request to run the domain reset sequence |
| hold_i | input | 1 | Keep the domain in reset while high |
| cfg_assert_len_i | input | CNT_W | Cycles of reset before clock stop (min 9) |
| cfg_clkoff_len_i | input | CNT_W | Cycles of stopped clock before reset release (min 1) |
| cfg_release_len_i | input | CNT_W | Cycles after release before clock restart (min 1) |
| dom_rst_n_o | output | 1 | Active-low domain reset |
| dom_clk_stop_o | output | 1 | Active-high domain clock-stop request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the clock restarts |

## Verification
A wrong phase register shows at the ports in the very next cycle, because all four outputs are flops decoded from the next phase: the pair of domain reset and clock-stop takes a combination that does not belong to the current step. An off-by-one in the countdown is invisible within a phase. It shows only at a phase boundary, as a run of the same output pair one cycle too long or too short, so the bench measures the length of every run. A lost hold or a misplaced start shows within one cycle, as a busy flag or a reset level that disagrees with the stimulus just applied.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_ASSERT  = 3'd1,
      PH_CLKOFF  = 3'd2,
      PH_RELEASE = 3'd3,
      PH_DONE    = 3'd4
   } phase_e;

   localparam int NUM_WAITS = 3;

   // Minimum length of each timed phase, indexed by wait number
   function automatic int min_wait(input int idx);
      case (idx)
         0:       return 9;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/vrs_len_sel.sv
module vrs_len_sel #(
   parameter int CNT_W    = 8,
   parameter int MIN_LEN  = 1,
   parameter int DEF_LEN  = 10,
   parameter bit USE_PORT = 1'b1
) (
   input  logic [CNT_W-1:0] cfg_len_i,
   output logic [CNT_W-1:0] len_o
);

   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_LEN);
   localparam logic [CNT_W-1:0] DEF_V = CNT_W'(DEF_LEN);

   initial begin
      AST_MIN_POSITIVE: assert (MIN_LEN >= 1 && MIN_LEN < (1 << CNT_W)); // R9
      AST_DEF_FITS: assert (DEF_LEN >= MIN_LEN && DEF_LEN < (1 << CNT_W)); // R9
   end

   logic [CNT_W-1:0] raw_len;

   generate
      if (USE_PORT) begin : g_port
         assign raw_len = cfg_len_i;
      end else begin : g_fixed
         logic unused_cfg;
         assign unused_cfg = ^cfg_len_i;
         assign raw_len    = DEF_V;
      end
   endgenerate

   assign len_o = (raw_len < MIN_V) ? MIN_V : raw_len;

endmodule

// File: rtl/vrs_phase_timer.sv
module vrs_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i - CNT_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expire_o = (cnt_q == '0);

   AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (load_val_i != '0)); // R9

   AST_EXPIRE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !load_i) |=> expire_o); // R5

endmodule

// File: rtl/vrs_phase_fsm.sv
module vrs_phase_fsm
   import vrs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       hold_i,
   input  logic       expire_i,
   output logic       load_o,
   output logic [1:0] sel_o,
   output logic       dom_rst_n_o,
   output logic       clk_stop_o,
   output logic       busy_o,
   output logic       done_o
);

   phase_e state_q, state_d;
   logic   hold_q;
   logic   launch;

   assign launch = !hold_i && (start_i || hold_q) &&
                   ((state_q == PH_IDLE) || (state_q == PH_DONE));

   always_comb begin
      state_d = state_q;
      case (state_q)
         PH_IDLE, PH_DONE: if (launch)   state_d = PH_ASSERT;
         PH_ASSERT:        if (expire_i) state_d = PH_CLKOFF;
         PH_CLKOFF:        if (expire_i) state_d = PH_RELEASE;
         PH_RELEASE:       if (expire_i) state_d = PH_DONE;
         default:                        state_d = PH_IDLE;
      endcase
      if (hold_i) state_d = PH_IDLE;
   end

   always_comb begin
      sel_o = 2'd0;
      case (state_d)
         PH_CLKOFF:  sel_o = 2'd1;
         PH_RELEASE: sel_o = 2'd2;
         default:    sel_o = 2'd0;
      endcase
   end

   assign load_o = (state_d != state_q) &&
                   ((state_d == PH_ASSERT) || (state_d == PH_CLKOFF) ||
                    (state_d == PH_RELEASE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PH_IDLE;
         hold_q      <= 1'b0;
         dom_rst_n_o <= 1'b0;
         clk_stop_o  <= 1'b0;
         busy_o      <= 1'b0;
         done_o      <= 1'b0;
      end else begin
         state_q     <= state_d;
         hold_q      <= hold_i;
         dom_rst_n_o <= (state_d == PH_RELEASE) || (state_d == PH_DONE);
         clk_stop_o  <= (state_d == PH_CLKOFF) || (state_d == PH_RELEASE);
         busy_o      <= (state_d == PH_ASSERT) || (state_d == PH_CLKOFF) ||
                        (state_d == PH_RELEASE);
         done_o      <= (state_d == PH_DONE) && (state_q != PH_DONE);
      end
   end

   AST_STOP_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_stop_o) |-> !dom_rst_n_o); // R3

   AST_RELEASE_UNDER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_rst_n_o) |-> clk_stop_o); // R4

   AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (dom_rst_n_o && !clk_stop_o && !busy_o)); // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R5

   AST_HOLD_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (!dom_rst_n_o && !clk_stop_o && !busy_o)); // R7

   AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !hold_i) |=> (busy_o && !dom_rst_n_o)); // R8

endmodule

// File: rtl/vec_rst_seq.sv
module vec_rst_seq #(
   parameter int CNT_W         = 8,
   parameter bit USE_CFG_PORTS = 1'b1,
   parameter int DEF_ASSERT    = 15,
   parameter int DEF_CLKOFF    = 10,
   parameter int DEF_RELEASE   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             hold_i,
   input  logic [CNT_W-1:0] cfg_assert_len_i,
   input  logic [CNT_W-1:0] cfg_clkoff_len_i,
   input  logic [CNT_W-1:0] cfg_release_len_i,
   output logic             dom_rst_n_o,
   output logic             dom_clk_stop_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam int NW = vrs_pkg::NUM_WAITS;
   localparam int DEF_LEN [NW] = '{DEF_ASSERT, DEF_CLKOFF, DEF_RELEASE};

   initial begin
      AST_CNT_WIDTH: assert (CNT_W >= 4 && CNT_W <= 24); // R9
   end

   logic [CNT_W-1:0] cfg_len [NW];
   logic [CNT_W-1:0] eff_len [NW];

   assign cfg_len[0] = cfg_assert_len_i;
   assign cfg_len[1] = cfg_clkoff_len_i;
   assign cfg_len[2] = cfg_release_len_i;

   generate
      for (genvar gi = 0; gi < NW; gi++) begin : g_len
         vrs_len_sel #(
            .CNT_W   (CNT_W),
            .MIN_LEN (vrs_pkg::min_wait(gi)),
            .DEF_LEN (DEF_LEN[gi]),
            .USE_PORT(USE_CFG_PORTS)
         ) u_sel (
            .cfg_len_i(cfg_len[gi]),
            .len_o    (eff_len[gi])
         );
      end
   endgenerate

   logic             load;
   logic [1:0]       sel;
   logic             expire;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      case (sel)
         2'd1:    load_val = eff_len[1];
         2'd2:    load_val = eff_len[2];
         default: load_val = eff_len[0];
      endcase
   end

   vrs_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .load_val_i(load_val),
      .expire_o  (expire)
   );

   vrs_phase_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .hold_i     (hold_i),
      .expire_i   (expire),
      .load_o     (load),
      .sel_o      (sel),
      .dom_rst_n_o(dom_rst_n_o),
      .clk_stop_o (dom_clk_stop_o),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy_o, done_o})); // R5

endmodule

// File: tb/vec_rst_seq_test.sv
`timescale 1ns/1ps
module vec_rst_seq_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       hold = 1'b0;
   logic [7:0] len_a = 8'd15;
   logic [7:0] len_c = 8'd10;
   logic [7:0] len_r = 8'd10;
   logic       drst_n, dstop, busy, done;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   vec_rst_seq uut (
      .clk              (clk),
      .rst_n            (rst_n),
      .start_i          (start),
      .hold_i           (hold),
      .cfg_assert_len_i (len_a),
      .cfg_clkoff_len_i (len_c),
      .cfg_release_len_i(len_r),
      .dom_rst_n_o      (drst_n),
      .dom_clk_stop_o   (dstop),
      .busy_o           (busy),
      .done_o           (done)
   );

   // cfg assert, cfg clkoff, cfg release, expected L1, L2, L3
   localparam int NV = 5;
   localparam int VEC [NV][6] = '{
      '{15, 10, 10, 15, 10, 10},
      '{ 9,  1,  1,  9,  1,  1},
      '{ 3,  0,  0,  9,  1,  1},
      '{20,  4,  7, 20,  4,  7},
      '{ 0,  2,  3,  9,  2,  3}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // packed {dom_rst_n, clk_stop, busy, done}
   function automatic int outs();
      return int'({drst_n, dstop, busy, done});
   endfunction

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic measure(input string req, input int e1, input int e2, input int e3);
      int c1 = 0;
      int c2 = 0;
      int c3 = 0;
      while (busy && !drst_n && !dstop && c1 < 300) begin c1++; @(negedge clk); end
      while (!drst_n && dstop && c2 < 300) begin c2++; @(negedge clk); end
      while (drst_n && dstop && c3 < 300) begin c3++; @(negedge clk); end
      check(c1 == e1, {req, " R2 assert phase"}, c1, e1);
      check(c2 == e2, {req, " R3 clkoff phase"}, c2, e2);
      check(c3 == e3, {req, " R4 release phase"}, c3, e3);
      check(outs() == 4'b1001, {req, " R5 done cycle"}, outs(), 4'b1001);
      @(negedge clk);
      check(outs() == 4'b1000, {req, " R5 after done"}, outs(), 4'b1000);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(outs() == 0, "R1 reset state", outs(), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(outs() == 0, "R1 idle after reset", outs(), 0);

      // vector table: lengths and clamping (R9)
      for (int i = 0; i < NV; i++) begin
         len_a = 8'(VEC[i][0]);
         len_c = 8'(VEC[i][1]);
         len_r = 8'(VEC[i][2]);
         pulse_start();
         measure("R9 vector", VEC[i][3], VEC[i][4], VEC[i][5]);
      end

      // R10: restart from done
      pulse_start();
      check(outs() == 4'b0010, "R10 restart from done", outs(), 4'b0010);
      measure("R10", 9, 2, 3);

      // R6: start while busy ignored
      len_a = 8'd15; len_c = 8'd10; len_r = 8'd10;
      pulse_start();
      repeat (19) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(outs() == 4'b0110, "R6 start ignored in clkoff", outs(), 4'b0110);
      measure("R6", 0, 5, 10);

      // R7 / R8: hold during release phase
      pulse_start();
      repeat (30) @(negedge clk);
      check(outs() == 4'b1110, "R4 in release phase", outs(), 4'b1110);
      hold = 1'b1;
      @(negedge clk);
      check(outs() == 0, "R7 hold forces reset", outs(), 0);
      repeat (4) @(negedge clk);
      check(outs() == 0, "R7 hold persists", outs(), 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(outs() == 0, "R7 start ignored under hold", outs(), 0);
      hold = 1'b0;
      @(negedge clk);
      check(outs() == 4'b0010, "R8 hold exit launches", outs(), 4'b0010);
      measure("R8", 15, 10, 10);

      // R1: asynchronous reset mid-sequence
      pulse_start();
      repeat (20) @(negedge clk);
      #1 rst_n = 1'b0;
      #1 check(outs() == 0, "R1 async reset mid-sequence", outs(), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(outs() == 0, "R1 idle after mid reset", outs(), 0);
      pulse_start();
      measure("R2 after reset", 15, 10, 10);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule